// File: doc/BRIEF.md
# Reorder Buffer with Register Alias Table

This block keeps program order for a core that executes out of order. A circular buffer gets one entry per dispatched instruction. Each instruction has one destination register. An alias table, indexed by architectural register number, records for every register whether its newest value sits in the architectural register file or in a buffer slot. It also records whether that buffer value is still outstanding.

Functional units hand back results by slot number. A result is held in the buffer only, and the alias table then reports it as available but speculative. The oldest entry retires once its result is present. Retiring writes the result into the architectural register file. If no younger instruction has since claimed the same register, retiring also points that register's alias back at the architectural copy. A flush drops every entry still in flight. After a flush, every register reads from the architectural file again.

Source lookups are combinational. Each lookup returns one of three answers: a committed value, a speculative value taken from the buffer, or the slot tag to wait on.

Top module: `rob_rat_top`

## Requirements
- R1: After reset the buffer is empty: `disp_ready`=1, `commit_valid`=0. Every lookup reports ready=1, speculative=0 and data 0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high at a clock edge. It receives the slot shown on `disp_slot` in that cycle. From the next cycle, a lookup of its destination reports ready=0 with `src_tag` equal to that slot.
- R3: After DEPTH accepted dispatches with no commit, `disp_ready` is 0. A dispatch offered while `disp_ready` is 0 is dropped: no slot is taken, and a lookup of its destination register is unchanged.
- R4: A completion writes `cmpl_data` into slot `cmpl_slot`. From the next cycle, a lookup of a register whose alias points at that slot reports ready=1, speculative=1 and that data.
- R5: `commit_valid` is high exactly when the oldest entry has completed (and no flush is applied). A completed younger entry does not commit before an older pending one. While `commit_valid` is high, `commit_reg`/`commit_data` give the oldest entry's destination and result, and the entry retires at that clock edge.
- R6: After a commit, a register whose alias pointed at the retired slot reads ready=1, speculative=0, with the committed value. A register already claimed by a younger entry keeps reporting that younger slot.
- R7: A flush empties the buffer (`disp_ready`=1, next slot is 0) and returns every alias to the architectural file, keeping committed values. An entry that would have committed in the flush cycle is discarded.
- R8: A completion naming a slot that is not occupied is ignored. A later dispatch into that slot still reads as pending.
- R9: Slots are handed out in increasing order modulo DEPTH and wrap from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all in-flight entries |
| disp_valid | input | 1 | Dispatch request |
| disp_dst | input | REG_W | Destination architectural register of the dispatch |
| disp_ready | output | 1 | Buffer has a free slot |
| disp_slot | output | TAG_W | Slot the dispatch receives |
| cmpl_valid | input | 1 | Result returned |
| cmpl_slot | input | TAG_W | Slot of the returned result |
| cmpl_data | input | XLEN | Returned result value |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_reg | output | REG_W | Destination of the retiring entry |
| commit_data | output | XLEN | Value of the retiring entry |
| src_reg | input | NUM_SRC*REG_W | Lookup register numbers, one field per lookup port |
| src_ready | output | NUM_SRC | Value available, per lookup port |
| src_spec | output | NUM_SRC | Value comes from the buffer, per lookup port |
| src_tag | output | NUM_SRC*TAG_W | Slot of the newest producer, per lookup port |
| src_data | output | NUM_SRC*XLEN | Value when ready, per lookup port |

## Verification
Completions are applied in program order and out of order. The out-of-order case separates a buffer that retires by head position from one that retires whatever finished. One register is written twice in flight, which shows whether a commit wrongly restores an alias that a younger producer already owns. The buffer is filled until it wraps and stalls, and a dispatch is offered while full. A flush is applied in the same cycle as a due commit, and a completion is sent to an emptied slot; these cases check the priority and the validity gating.

// File: rtl/rob_rat_pkg.sv
// Shared definitions for the reorder buffer / alias table block.
// Assumes nothing beyond standard SystemVerilog packages.
package rob_rat_pkg;

    // Where a source operand currently lives.
    typedef enum logic [1:0] {
        KIND_ARCH = 2'd0,
        KIND_SPEC = 2'd1,
        KIND_WAIT = 2'd2
    } src_kind_e;

    // Classify an alias entry into an operand location.
    function automatic src_kind_e classify(input logic in_buf, input logic pending);
        if (!in_buf)      return KIND_ARCH;
        else if (pending) return KIND_WAIT;
        else              return KIND_SPEC;
    endfunction

endpackage

// File: rtl/rob_rat_ring.sv
// Circular entry store: allocates at the tail, takes results by slot, and
// retires from the head. Assumes the caller never allocates when full and
// never retires an entry that is not complete.
module rob_rat_ring #(
    parameter int DEPTH  = 8,
    parameter int NUM_RD = 2,
    parameter int REG_W  = 4,
    parameter int XLEN   = 32,
    parameter int TAG_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    alloc_en,
    input  logic [REG_W-1:0]        alloc_dst,
    output logic [TAG_W-1:0]        tail_slot,
    input  logic                    fill_en,
    input  logic [TAG_W-1:0]        fill_slot,
    input  logic [XLEN-1:0]         fill_data,
    output logic                    fill_live,
    input  logic                    retire_en,
    output logic                    head_ready,
    output logic [REG_W-1:0]        head_dst,
    output logic [XLEN-1:0]         head_data,
    output logic [CNT_W-1:0]        occupancy,
    input  logic [NUM_RD*TAG_W-1:0] rd_slot,
    output logic [NUM_RD*XLEN-1:0]  rd_data
);

    logic [TAG_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;
    logic [DEPTH-1:0] valid_q, done_q;
    logic [REG_W-1:0] dst_q  [DEPTH];
    logic [XLEN-1:0]  data_q [DEPTH];

    // Advance a slot pointer with wrap at DEPTH-1.
    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointers, occupancy and per-entry status flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            valid_q <= '0;
            done_q  <= '0;
        end else begin
            if (alloc_en) begin
                valid_q[tail_q] <= 1'b1;
                done_q[tail_q]  <= 1'b0;
                tail_q          <= bump(tail_q);
            end
            if (fill_en && valid_q[fill_slot]) begin
                done_q[fill_slot] <= 1'b1;
            end
            if (retire_en) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= bump(head_q);
            end
            count_q <= count_q + CNT_W'(alloc_en) - CNT_W'(retire_en);
        end
    end

    // Entry payload: destination on allocation, result on completion.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            dst_q[tail_q] <= alloc_dst;
        end
        if (fill_en && valid_q[fill_slot]) begin
            data_q[fill_slot] <= fill_data;
        end
    end

    assign tail_slot  = tail_q;
    assign fill_live  = fill_en && valid_q[fill_slot];
    assign head_ready = valid_q[head_q] && done_q[head_q];
    assign head_dst   = dst_q[head_q];
    assign head_data  = data_q[head_q];
    assign occupancy  = count_q;

    // One combinational result read per lookup port.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data[p*XLEN +: XLEN] = data_q[rd_slot[p*TAG_W +: TAG_W]];
    end

endmodule

// File: rtl/rob_rat_alias.sv
// Register alias table: per architectural register, a flag saying the newest
// value is in the buffer, the slot holding it, and a pending flag. Assumes
// allocation of a register takes priority over retirement of its old slot.
module rob_rat_alias #(
    parameter int NREG   = 16,
    parameter int NUM_RD = 2,
    parameter int REG_W  = $clog2(NREG),
    parameter int TAG_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    alloc_en,
    input  logic [REG_W-1:0]        alloc_reg,
    input  logic [TAG_W-1:0]        alloc_slot,
    input  logic                    fill_en,
    input  logic [TAG_W-1:0]        fill_slot,
    input  logic                    retire_en,
    input  logic [REG_W-1:0]        retire_reg,
    input  logic [TAG_W-1:0]        retire_slot,
    input  logic [NUM_RD*REG_W-1:0] rd_reg,
    output logic [NUM_RD-1:0]       rd_in_buf,
    output logic [NUM_RD-1:0]       rd_pending,
    output logic [NUM_RD*TAG_W-1:0] rd_slot
);

    logic [NREG-1:0]  in_buf_q, pending_q;
    logic [TAG_W-1:0] slot_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        // Redirect on dispatch, clear pending on result, restore on commit.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                in_buf_q[g]  <= 1'b0;
                pending_q[g] <= 1'b0;
                slot_q[g]    <= '0;
            end else if (alloc_en && alloc_reg == REG_W'(g)) begin
                in_buf_q[g]  <= 1'b1;
                pending_q[g] <= 1'b1;
                slot_q[g]    <= alloc_slot;
            end else begin
                if (fill_en && in_buf_q[g] && slot_q[g] == fill_slot) begin
                    pending_q[g] <= 1'b0;
                end
                if (retire_en && retire_reg == REG_W'(g) && in_buf_q[g]
                    && slot_q[g] == retire_slot) begin
                    in_buf_q[g] <= 1'b0;
                end
            end
        end
    end

    // Combinational alias reads, one per lookup port.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_in_buf[p]              = in_buf_q[rd_reg[p*REG_W +: REG_W]];
        assign rd_pending[p]             = pending_q[rd_reg[p*REG_W +: REG_W]];
        assign rd_slot[p*TAG_W +: TAG_W] = slot_q[rd_reg[p*REG_W +: REG_W]];
    end

endmodule

// File: rtl/rob_rat_regfile.sv
// Architectural register file, written only by retiring entries.
// Assumes one write per cycle; all registers clear to zero on reset.
module rob_rat_regfile #(
    parameter int NREG   = 16,
    parameter int NUM_RD = 2,
    parameter int XLEN   = 32,
    parameter int REG_W  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_W-1:0]        wr_reg,
    input  logic [XLEN-1:0]         wr_data,
    input  logic [NUM_RD*REG_W-1:0] rd_reg,
    output logic [NUM_RD*XLEN-1:0]  rd_data
);

    logic [XLEN-1:0] regs_q [NREG];

    // Committed state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_reg] <= wr_data;
        end
    end

    // Combinational reads, one per lookup port.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_data[p*XLEN +: XLEN] = regs_q[rd_reg[p*REG_W +: REG_W]];
    end

endmodule

// File: rtl/rob_rat_top.sv
// Reorder buffer with register alias table. Dispatch allocates at the tail
// and claims the destination alias; completions fill slots; the head retires
// into the register file in order; flush drops all in-flight work.
// Assumes DEPTH is a power of two and each instruction has one destination.
module rob_rat_top #(
    parameter int DEPTH   = 8,
    parameter int NREG    = 16,
    parameter int XLEN    = 32,
    parameter int NUM_SRC = 2,
    parameter int TAG_W   = $clog2(DEPTH),
    parameter int REG_W   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     disp_valid,
    input  logic [REG_W-1:0]         disp_dst,
    output logic                     disp_ready,
    output logic [TAG_W-1:0]         disp_slot,
    input  logic                     cmpl_valid,
    input  logic [TAG_W-1:0]         cmpl_slot,
    input  logic [XLEN-1:0]          cmpl_data,
    output logic                     commit_valid,
    output logic [REG_W-1:0]         commit_reg,
    output logic [XLEN-1:0]          commit_data,
    input  logic [NUM_SRC*REG_W-1:0] src_reg,
    output logic [NUM_SRC-1:0]       src_ready,
    output logic [NUM_SRC-1:0]       src_spec,
    output logic [NUM_SRC*TAG_W-1:0] src_tag,
    output logic [NUM_SRC*XLEN-1:0]  src_data
);
    import rob_rat_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic                     alloc_en, fill_live, head_ready;
    logic [CNT_W-1:0]         occ_count;
    logic [NUM_SRC-1:0]       al_in_buf, al_pending;
    logic [NUM_SRC*TAG_W-1:0] al_slot;
    logic [NUM_SRC*XLEN-1:0]  buf_data, arch_data;

    assign disp_ready   = (occ_count != FULL_CNT);
    assign alloc_en     = disp_valid && disp_ready && !flush;
    assign commit_valid = head_ready && !flush;

    rob_rat_ring #(
        .DEPTH(DEPTH), .NUM_RD(NUM_SRC), .REG_W(REG_W), .XLEN(XLEN),
        .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_en(alloc_en), .alloc_dst(disp_dst), .tail_slot(disp_slot),
        .fill_en(cmpl_valid), .fill_slot(cmpl_slot), .fill_data(cmpl_data),
        .fill_live(fill_live),
        .retire_en(commit_valid), .head_ready(head_ready),
        .head_dst(commit_reg), .head_data(commit_data),
        .occupancy(occ_count),
        .rd_slot(al_slot), .rd_data(buf_data)
    );

    rob_rat_alias #(
        .NREG(NREG), .NUM_RD(NUM_SRC), .REG_W(REG_W), .TAG_W(TAG_W)
    ) u_alias (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_en(alloc_en), .alloc_reg(disp_dst), .alloc_slot(disp_slot),
        .fill_en(fill_live), .fill_slot(cmpl_slot),
        .retire_en(commit_valid), .retire_reg(commit_reg),
        .retire_slot(u_ring.head_q),
        .rd_reg(src_reg), .rd_in_buf(al_in_buf), .rd_pending(al_pending),
        .rd_slot(al_slot)
    );

    rob_rat_regfile #(
        .NREG(NREG), .NUM_RD(NUM_SRC), .XLEN(XLEN), .REG_W(REG_W)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_valid), .wr_reg(commit_reg), .wr_data(commit_data),
        .rd_reg(src_reg), .rd_data(arch_data)
    );

    // Per lookup port: choose committed value, buffer value, or wait tag.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        src_kind_e kind;
        assign kind = classify(al_in_buf[s], al_pending[s]);
        always_comb begin
            src_tag[s*TAG_W +: TAG_W] = al_slot[s*TAG_W +: TAG_W];
            unique case (kind)
                KIND_ARCH: begin
                    src_ready[s]              = 1'b1;
                    src_spec[s]               = 1'b0;
                    src_tag[s*TAG_W +: TAG_W] = '0;
                    src_data[s*XLEN +: XLEN]  = arch_data[s*XLEN +: XLEN];
                end
                KIND_SPEC: begin
                    src_ready[s]             = 1'b1;
                    src_spec[s]              = 1'b1;
                    src_data[s*XLEN +: XLEN] = buf_data[s*XLEN +: XLEN];
                end
                default: begin
                    src_ready[s]             = 1'b0;
                    src_spec[s]              = 1'b0;
                    src_data[s*XLEN +: XLEN] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rob_rat_checker.sv
// Protocol checks on occupancy, dispatch, commit and flush of rob_rat_top.
// Assumes reset is applied at time zero.
module rob_rat_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic             commit_valid,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R3
    AST_DISP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready && !flush && !commit_valid
        |=> count == CNT_W'($past(count) + 1'b1)); // R2
    AST_COMMIT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid && !(disp_valid && disp_ready)
        |=> count == CNT_W'($past(count) - 1'b1)); // R5
    AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count == '0 |-> !commit_valid); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0 && disp_ready && !commit_valid); // R7

endmodule

bind rob_rat_top rob_rat_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .commit_valid(commit_valid), .count(occ_count)
);

// File: tb/tb_rob_rat_top.sv
// Directed bench for rob_rat_top: one task per scenario.
module tb_rob_rat_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8, NREG = 16, XLEN = 32, NSRC = 2;
    localparam int TW = 3, RW = 4;

    logic clk = 0, rst_n = 0, flush = 0;
    logic disp_valid = 0;
    logic [RW-1:0] disp_dst = '0;
    logic disp_ready;
    logic [TW-1:0] disp_slot;
    logic cmpl_valid = 0;
    logic [TW-1:0] cmpl_slot = '0;
    logic [XLEN-1:0] cmpl_data = '0;
    logic commit_valid;
    logic [RW-1:0] commit_reg;
    logic [XLEN-1:0] commit_data;
    logic [NSRC*RW-1:0] src_reg = '0;
    logic [NSRC-1:0] src_ready, src_spec;
    logic [NSRC*TW-1:0] src_tag;
    logic [NSRC*XLEN-1:0] src_data;

    int n_chk = 0, n_fail = 0;

    rob_rat_top #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .NUM_SRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_dst(disp_dst), .disp_ready(disp_ready),
        .disp_slot(disp_slot), .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot),
        .cmpl_data(cmpl_data), .commit_valid(commit_valid),
        .commit_reg(commit_reg), .commit_data(commit_data),
        .src_reg(src_reg), .src_ready(src_ready), .src_spec(src_spec),
        .src_tag(src_tag), .src_data(src_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic dispatch(input int r, input int exp_slot, input string req);
        disp_valid = 1; disp_dst = RW'(r);
        #1;
        chk(req, 32'(disp_slot), exp_slot);
        step();
        disp_valid = 0;
    endtask

    task automatic complete(input int slot, input logic [31:0] d);
        cmpl_valid = 1; cmpl_slot = TW'(slot); cmpl_data = d;
        step();
        cmpl_valid = 0;
    endtask

    // Lookup on a chosen port; checks ready, spec, and tag or data.
    task automatic look(input int port, input int r, input logic rdy, input logic spc,
                        input logic [31:0] tag_or_data, input string req);
        src_reg[port*RW +: RW] = RW'(r);
        #1;
        chk({req, " ready"}, 32'(src_ready[port]), 32'(rdy));
        chk({req, " spec"},  32'(src_spec[port]),  32'(spc));
        if (rdy) chk({req, " data"}, src_data[port*XLEN +: XLEN], tag_or_data);
        else     chk({req, " tag"},  32'(src_tag[port*TW +: TW]), tag_or_data);
    endtask

    task automatic wait_commit(input int r, input logic [31:0] d, input string req);
        int k;
        for (k = 0; k < 20 && !commit_valid; k++) step();
        chk({req, " commit_valid"}, 32'(commit_valid), 1);
        chk({req, " commit_reg"}, 32'(commit_reg), r);
        chk({req, " commit_data"}, commit_data, d);
        step();
    endtask

    task automatic t_reset();
        chk("R1 disp_ready", 32'(disp_ready), 1);
        chk("R1 commit_valid", 32'(commit_valid), 0);
        look(0, 3, 1, 0, 0, "R1 lookup r3");
    endtask

    task automatic t_out_of_order();
        dispatch(5, 0, "R2 slot r5");
        dispatch(6, 1, "R2 slot r6");
        look(0, 5, 0, 0, 0, "R2 r5 pending");
        look(1, 6, 0, 0, 1, "R2 r6 pending");
        complete(1, 32'hB);
        look(0, 6, 1, 1, 32'hB, "R4 r6 speculative");
        chk("R5 younger waits", 32'(commit_valid), 0);
        complete(0, 32'hA);
        wait_commit(5, 32'hA, "R5 head first");
        wait_commit(6, 32'hB, "R5 second");
        look(0, 5, 1, 0, 32'hA, "R6 r5 restored");
        look(1, 6, 1, 0, 32'hB, "R6 r6 restored");
        chk("R5 drained", 32'(commit_valid), 0);
    endtask

    task automatic t_newer_producer();
        dispatch(5, 2, "R2 slot r5a");
        dispatch(5, 3, "R2 slot r5b");
        complete(2, 32'hC);
        wait_commit(5, 32'hC, "R5 older r5");
        look(0, 5, 0, 0, 3, "R6 newer kept");
        complete(3, 32'hD);
        wait_commit(5, 32'hD, "R5 newer r5");
        look(0, 5, 1, 0, 32'hD, "R6 final r5");
    endtask

    task automatic t_full_and_flush();
        for (int i = 0; i < DEPTH; i++) dispatch(i, (4 + i) % DEPTH, "R9 wrap slot");
        chk("R3 full stall", 32'(disp_ready), 0);
        disp_valid = 1; disp_dst = 4'd8;
        step();
        disp_valid = 0;
        look(0, 8, 1, 0, 0, "R3 dropped dispatch");
        chk("R3 still full", 32'(disp_ready), 0);
        flush = 1; step(); flush = 0;
        chk("R7 ready after flush", 32'(disp_ready), 1);
        chk("R7 no commit", 32'(commit_valid), 0);
        look(0, 0, 1, 0, 0, "R7 r0 arch");
        look(1, 5, 1, 0, 32'hD, "R7 r5 kept");
    endtask

    task automatic t_flush_vs_commit();
        dispatch(9, 0, "R7 slot restarts");
        complete(0, 32'hE);
        chk("R5 due", 32'(commit_valid), 1);
        flush = 1; step(); flush = 0;
        look(0, 9, 1, 0, 0, "R7 commit discarded");
        chk("R7 empty", 32'(commit_valid), 0);
    endtask

    task automatic t_stale_completion();
        complete(0, 32'hF);
        chk("R8 no commit", 32'(commit_valid), 0);
        dispatch(10, 0, "R8 slot");
        look(0, 10, 0, 0, 0, "R8 still pending");
        complete(0, 32'h10);
        wait_commit(10, 32'h10, "R8 real result");
        look(1, 10, 1, 0, 32'h10, "R6 r10 restored");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_out_of_order();
        t_newer_producer();
        t_full_and_flush();
        t_flush_vs_commit();
        t_stale_completion();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule